// File: doc/BRIEF.md
# Compare-and-Skip Predication Unit

This unit sits between instruction decode and execute in a small 16-bit RISC pipeline and is the core's only form of conditional execution. A compare instruction tests a condition on two register operands. If the condition is true, it arms a one-shot skip flag. The compare writes no register and does not branch. The next decoded instruction that reaches the unit while the flag is armed is cancelled: it keeps its pipeline slot, but execute receives a kill strobe so that it writes no register, memory or flag. A conditional branch is written as a compare followed by an ordinary jump.

An immediate prefix and the instruction it extends form one unit. A cancelled prefix leaves the flag armed, so the instruction it extends is cancelled as well. Compares, prefixes and instructions marked non-interruptible raise an interrupt hold. The hold is also raised for as long as a skip is armed, so interrupt entry never falls between a compare and its victim. Each compare carries a 3-bit condition field. There are two compare forms: plain, and carry-aware. The carry-aware form folds the incoming carry into the subtraction, which allows multi-word comparisons.

Top module: `skip_predicate_unit`

## Requirements
- R1: A synchronous active-high reset disarms the skip flag. After reset, a valid non-compare instruction sees out_kill=0, and out_irq_hold=0 if it is neither a prefix nor marked non-interruptible.
- R2: A valid compare whose condition is true, presented while no skip is armed, causes out_kill=1 on the next valid instruction. A false condition causes out_kill=0 on that instruction. A valid non-compare instruction that is not cancelled leaves the flag disarmed.
- R3: Only one instruction is cancelled. After a cancelled instruction that is not a prefix, the next valid instruction has out_kill=0.
- R4: A cancelled prefix (in_is_prefix=1) keeps the flag armed. Both the prefix and the following valid instruction are cancelled, and the instruction after those two runs.
- R5: A compare that is itself cancelled does not evaluate its condition and disarms the flag. The next valid instruction is not cancelled.
- R6: In the plain form (in_carry_form=0), the in_cond codes are: 0 EQ (a==b), 1 NE, 2 LT (signed a<b), 3 GE (signed), 4 LTU (unsigned a<b), 5 GEU (unsigned).
- R7: In the carry-aware form (in_carry_form=1), codes 0 to 5 apply the same tests to the exact result of a−b−in_carry: EQ means that result is zero modulo 2^16; LT and LTU mean the exact signed or unsigned result is negative.
- R8: Code 6 is true when in_carry=1 and code 7 is true when in_carry=0, in both forms.
- R9: A cycle with in_valid=0 never asserts out_kill and leaves the armed or disarmed state unchanged.
- R10: out_irq_hold is 1 exactly when a skip is armed, or when a valid instruction is a compare, a prefix, or marked non-interruptible (in_no_intr=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is present this cycle |
| in_is_cmp | input | 1 | The instruction is a compare-and-skip |
| in_carry_form | input | 1 | The compare is the carry-aware form |
| in_cond | input | 3 | Condition code of the compare |
| in_is_prefix | input | 1 | The instruction is an immediate prefix |
| in_no_intr | input | 1 | The instruction is otherwise non-interruptible |
| in_op_a | input | W | First compare operand |
| in_op_b | input | W | Second compare operand |
| in_carry | input | 1 | Current carry flag |
| out_kill | output | 1 | Cancel the instruction in this slot |
| out_irq_hold | output | 1 | Hold off interrupt entry this cycle |

## Verification
Two functions can act in the same cycle: cancelling the current instruction, and deciding the next state of the flag from that same instruction. They collide when the victim is itself a compare (it must be cancelled and must not re-arm the flag) or a prefix (it must be cancelled and must keep the flag armed). The bench provokes both cases with directed true-compare chains and prefix pairs, and again inside a long mixed random stream that also contains bubbles. A behavioural model predicts out_kill and out_irq_hold for every slot and compares them each cycle. Each mismatch is charged to the requirement that governs the slot.

// File: rtl/skip_pkg.sv
package skip_pkg;

    typedef enum logic [2:0] {
        COND_EQ  = 3'd0,
        COND_NE  = 3'd1,
        COND_LT  = 3'd2,
        COND_GE  = 3'd3,
        COND_LTU = 3'd4,
        COND_GEU = 3'd5,
        COND_CYS = 3'd6,
        COND_CYC = 3'd7
    } skip_cond_e;

    typedef struct packed {
        logic       is_cmp;
        logic       carry_form;
        skip_cond_e cond;
        logic       is_prefix;
        logic       no_intr;
    } slot_ctl_t;

    // A cancelled slot of this kind leaves the skip armed for its partner.
    function automatic logic keeps_skip(slot_ctl_t s);
        return s.is_prefix;
    endfunction

    // Slots across which interrupt entry must not be taken.
    function automatic logic blocks_irq(slot_ctl_t s);
        return s.is_prefix | s.is_cmp | s.no_intr;
    endfunction

endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
    import skip_pkg::*;
#(
    parameter int W = 16
) (
    input  skip_cond_e     cond,
    input  logic           carry_form,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           carry,
    output logic           hit
);
    localparam int XW = W + 1;

    logic          borrow;
    logic [XW-1:0] borrow_x;
    logic [XW-1:0] udiff;
    logic [XW-1:0] sdiff;
    logic          is_zero;

    assign borrow   = carry_form & carry;
    assign borrow_x = {{W{1'b0}}, borrow};
    assign udiff    = {1'b0, op_a} - {1'b0, op_b} - borrow_x;
    assign sdiff    = {op_a[W-1], op_a} - {op_b[W-1], op_b} - borrow_x;
    assign is_zero  = (udiff[W-1:0] == '0);

    always_comb begin
        unique case (cond)
            COND_EQ:  hit = is_zero;
            COND_NE:  hit = ~is_zero;
            COND_LT:  hit = sdiff[W];
            COND_GE:  hit = ~sdiff[W];
            COND_LTU: hit = udiff[W];
            COND_GEU: hit = ~udiff[W];
            COND_CYS: hit = carry;
            default:  hit = ~carry;
        endcase
    end

endmodule

// File: rtl/skip_flag_ctrl.sv
module skip_flag_ctrl
    import skip_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  slot_ctl_t ctl,
    input  logic      hit,
    output logic      armed,
    output logic      kill
);
    logic armed_d;

    always_comb begin
        kill    = valid & armed;
        armed_d = armed;
        if (valid) begin
            if (armed)
                armed_d = keeps_skip(ctl);
            else
                armed_d = ctl.is_cmp & hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else
            armed <= armed_d;
    end

endmodule

// File: rtl/skip_predicate_unit.sv
module skip_predicate_unit
    import skip_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_is_cmp,
    input  logic         in_carry_form,
    input  logic [2:0]   in_cond,
    input  logic         in_is_prefix,
    input  logic         in_no_intr,
    input  logic [W-1:0] in_op_a,
    input  logic [W-1:0] in_op_b,
    input  logic         in_carry,
    output logic         out_kill,
    output logic         out_irq_hold
);
    slot_ctl_t ctl;
    logic      hit;
    logic      skip_q;

    assign ctl = '{is_cmp:     in_is_cmp,
                   carry_form: in_carry_form,
                   cond:       skip_cond_e'(in_cond),
                   is_prefix:  in_is_prefix,
                   no_intr:    in_no_intr};

    skip_cond_eval #(.W(W)) eval_i (
        .cond       (ctl.cond),
        .carry_form (ctl.carry_form),
        .op_a       (in_op_a),
        .op_b       (in_op_b),
        .carry      (in_carry),
        .hit        (hit)
    );

    skip_flag_ctrl flag_i (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .ctl   (ctl),
        .hit   (hit),
        .armed (skip_q),
        .kill  (out_kill)
    );

    assign out_irq_hold = skip_q | (in_valid & blocks_irq(ctl));

endmodule

// File: rtl/skip_predicate_unit_chk.sv
module skip_predicate_unit_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_is_cmp,
    input logic in_is_prefix,
    input logic out_kill,
    input logic out_irq_hold,
    input logic skip_pending
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !skip_pending);

    p_plain_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !skip_pending && !in_is_cmp) |=> !skip_pending);

    p_single_victim_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_kill && !in_is_prefix) |=> !out_kill);

    p_prefix_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_kill && in_is_prefix) |=> skip_pending);

    p_killed_cmp_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_kill && in_is_cmp && !in_is_prefix) |=> !skip_pending);

    p_bubble_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (skip_pending == $past(skip_pending)));

    p_pending_irq_r10: assert property (@(posedge clk) disable iff (rst)
        skip_pending |-> out_irq_hold);

endmodule

bind skip_predicate_unit skip_predicate_unit_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_is_cmp    (in_is_cmp),
    .in_is_prefix (in_is_prefix),
    .out_kill     (out_kill),
    .out_irq_hold (out_irq_hold),
    .skip_pending (skip_q)
);

// File: tb/skip_predicate_unit_tb_top.sv
module skip_predicate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v = 1'b0, cmp = 1'b0, cf = 1'b0, pre = 1'b0, noi = 1'b0, cy = 1'b0;
    logic [2:0]  cc = 3'd0;
    logic [15:0] a = 16'd0, b = 16'd0;
    logic        kill, hold;

    int total = 0;
    int fails = 0;
    bit pend = 1'b0;
    bit after_kill = 1'b0;
    string src_tag = "R2";
    string last_cmp = "R2";

    always #5 clk = ~clk;

    skip_predicate_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(v), .in_is_cmp(cmp), .in_carry_form(cf),
        .in_cond(cc), .in_is_prefix(pre), .in_no_intr(noi), .in_op_a(a),
        .in_op_b(b), .in_carry(cy), .out_kill(kill), .out_irq_hold(hold));

    function automatic bit ref_cond(input bit f, input int c, input int ua, input int ub, input bit ci);
        int bi, sa, sb, ud, sd;
        bi = (f && ci) ? 1 : 0;
        sa = (ua >= 32768) ? ua - 65536 : ua;
        sb = (ub >= 32768) ? ub - 65536 : ub;
        ud = ua - ub - bi;
        sd = sa - sb - bi;
        case (c)
            0: return ((ud + 131072) % 65536) == 0;
            1: return ((ud + 131072) % 65536) != 0;
            2: return sd < 0;
            3: return sd >= 0;
            4: return ud < 0;
            5: return ud >= 0;
            6: return ci;
            default: return !ci;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit iv, input bit icmp, input bit icf, input int icc,
                        input bit ipre, input bit inoi, input int ia, input int ib, input bit icy);
        string kt;
        @(negedge clk);
        v = iv; cmp = icmp; cf = icf; cc = 3'(icc); pre = ipre; noi = inoi;
        a = 16'(ia); b = 16'(ib); cy = icy;
        #2;
        if (!iv) kt = "R9";
        else if (pend && ipre) kt = "R4";
        else if (pend && icmp) kt = "R5";
        else if (pend) kt = src_tag;
        else if (after_kill) kt = "R3";
        else kt = last_cmp;
        check(kt, "kill", kill, iv && pend);
        check("R10", "irq_hold", hold, pend || (iv && (ipre || icmp || inoi)));
        @(posedge clk);
        if (iv) begin
            after_kill = pend && !ipre;
            last_cmp = "R2";
            if (pend) begin
                pend = ipre;
            end else begin
                pend = icmp && ref_cond(icf, icc, ia, ib, icy);
                if (icmp) begin
                    src_tag = (icc >= 6) ? "R8" : (icf ? "R7" : "R6");
                    last_cmp = src_tag;
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; v = 1'b1; cmp = 1'b1; cc = 3'd0; a = 16'd1; b = 16'd1;
        @(posedge clk);
        pend = 1'b0; after_kill = 1'b0; last_cmp = "R1";
        @(negedge clk);
        rst = 1'b0; v = 1'b0; cmp = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        step(1,0,0,0,0,0,0,0,0);              // R1 plain after reset
        step(1,1,0,0,0,0,5,5,0);              // R6 EQ true
        step(1,0,0,0,0,0,0,0,0);              // killed
        step(1,0,0,0,0,0,0,0,0);              // R3 runs
        step(1,1,0,1,0,0,5,5,0);              // R6 NE false
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,2,0,0,16'hFFFF,1,0);       // R6 LT signed true
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,4,0,0,16'hFFFF,1,0);       // R6 LTU false
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,3,0,0,3,3,0);              // GE true, then prefix pair R4
        step(1,0,0,0,1,0,0,0,0);
        step(1,0,0,0,0,0,0,0,0);
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,5,0,0,9,2,0);              // GEU true, chained compare R5
        step(1,1,0,0,0,0,7,7,0);
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,0,0,0,2,2,0);              // R9 bubbles keep skip
        step(0,0,0,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0,0,0);
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,1,0,0,0,5,4,1);              // R7 carry EQ true
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,0,0,0,5,4,1);              // plain ignores carry: false
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,1,4,0,0,4,4,1);              // R7 LTU via borrow
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,0,6,0,0,0,0,1);              // R8 carry set
        step(1,0,0,0,0,0,0,0,0);
        step(1,1,1,7,0,0,0,0,1);              // R8 carry clear false
        step(1,0,0,0,0,1,0,0,0);              // R10 non-interruptible marker
        step(1,1,0,0,0,0,1,1,0);              // arm, then reset R1
        do_reset();
        step(1,0,0,0,0,0,0,0,0);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            step(r != 0, r >= 6, $urandom_range(0,1) == 1, $urandom_range(0,7),
                 r == 4 || r == 5, r == 3, $urandom_range(0,3) == 0 ? 16'hFFFF : $urandom_range(0,4),
                 $urandom_range(0,4), $urandom_range(0,1) == 1);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule